// File: doc/BRIEF.md
# Load-Band Switching Frequency Selector

This block sits between a digitized load-current measurement and the switch sequencer of a step-down converter. It sorts each load sample into one of three bands, light, medium or heavy, by comparing it against two programmable thresholds. It then runs the converter's switching period at one of three programmable lengths, counted in system clocks, and emits a one-clock pulse at the start of every period. Heavy load uses the shortest period and light load the longest. The block also tells the sequencer which conduction style suits the band: the discontinuous style for light load, and the pseudo-continuous style for medium and heavy load.

A band change must be confirmed before it is accepted. The new band has to appear on a set number of consecutive valid samples, which stops the selector from chattering when the load sits near a threshold. A confirmed band, and its period length, take effect only at the next period boundary. No switching period is ever cut short or stretched. Typical threshold settings are about a quarter and about a tenth of the full-load code. Typical period values give a 4:2:1 frequency ratio between heavy, medium and light load.

Top module: `load_hop_selector`

## Requirements
- R1: A synchronous active-high reset selects the heavy band. After reset, band_code is 2'b10, dcm_req is 0, and period_start and band_change are 0.
- R2: A valid sample is classified as follows. Above thr_upper it is heavy (code 2'b10). Below thr_lower it is light (code 2'b00). Otherwise it is medium (code 2'b01), and this includes a sample exactly equal to either threshold. Code 2'b11 never appears.
- R3: A band is confirmed only when QUAL_M consecutive valid samples give that band. A sample of a different band restarts the count. Cycles with load_valid low neither advance nor break the count.
- R4: period_start is a one-clock pulse. Pulses repeat every P clocks, where P is the period register of the band in force (per_heavy, per_medium or per_light). A register value below 2 is treated as 2.
- R5: band_code and dcm_req change only in a cycle where period_start is high. At each pulse, they take the band that was confirmed when that period ended.
- R6: dcm_req is 1 exactly when band_code is light (2'b00), and is 0 for medium and heavy.
- R7: band_change is a one-clock pulse. It coincides with period_start exactly when the band in force differs from the band of the period before.
- R8: The period length is captured at each boundary. A write to a period register during a period has no effect on that period's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| load_valid | input | 1 | Qualifies load_sample for this cycle |
| load_sample | input | LOAD_W | Digitized load-current code |
| thr_upper | input | LOAD_W | Heavy/medium boundary |
| thr_lower | input | LOAD_W | Medium/light boundary |
| per_heavy | input | PER_W | Period length in clocks for heavy load |
| per_medium | input | PER_W | Period length in clocks for medium load |
| per_light | input | PER_W | Period length in clocks for light load |
| period_start | output | 1 | One-clock pulse at each switching period start |
| band_code | output | 2 | Band in force: 00 light, 01 medium, 10 heavy |
| dcm_req | output | 1 | 1 requests discontinuous conduction |
| band_change | output | 1 | One-clock pulse when the band in force switches |

## Verification
The period boundary and the band switch can fall in the same cycle: period_start, band_change, band_code and dcm_req must all move together on that one edge. To provoke this, the bench moves the load between bands while the periods are short. It also rewrites the period registers in mid-period, so that confirmations land close to, and on, the final count of a period. A cycle-accurate bench model judges each output on every cycle. Directed period-gap measurements confirm that a mid-period write leaves the running period whole.

// File: rtl/hop_pkg.sv
package hop_pkg;

  typedef enum logic [1:0] {
    BAND_LIGHT  = 2'b00,
    BAND_MEDIUM = 2'b01,
    BAND_HEAVY  = 2'b10
  } band_e;

  localparam int unsigned MIN_PERIOD = 2;

endpackage

// File: rtl/hop_band_classifier.sv
// Sorts one load code into a band; equality with a threshold counts as medium.
module hop_band_classifier
  import hop_pkg::*;
#(
  parameter int unsigned LOAD_W = 10
) (
  input  logic [LOAD_W-1:0] sample,
  input  logic [LOAD_W-1:0] thr_hi,
  input  logic [LOAD_W-1:0] thr_lo,
  output band_e             cls
);

  logic above_hi;
  logic below_lo;

  assign above_hi = sample > thr_hi;
  assign below_lo = sample < thr_lo;

  always_comb begin
    if (above_hi)      cls = BAND_HEAVY;
    else if (below_lo) cls = BAND_LIGHT;
    else               cls = BAND_MEDIUM;
  end

endmodule

// File: rtl/hop_band_qualifier.sv
// Confirms a band after QUAL_M consecutive valid samples of that band.
module hop_band_qualifier
  import hop_pkg::*;
#(
  parameter int unsigned QUAL_M = 4
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  valid,
  input  band_e cls,
  output band_e qual
);

  localparam int unsigned SW = $clog2(QUAL_M + 1);
  localparam logic [SW-1:0] STREAK_MAX = SW'(QUAL_M);
  localparam logic [SW-1:0] STREAK_ONE = SW'(1);

  logic [SW-1:0] streak_q;
  logic [SW-1:0] streak_d;
  band_e         last_q;
  band_e         qual_q;
  logic          same_run;

  assign same_run = (cls == last_q) && (streak_q != '0);

  always_comb begin
    if (!same_run)                  streak_d = STREAK_ONE;
    else if (streak_q == STREAK_MAX) streak_d = streak_q;
    else                            streak_d = streak_q + STREAK_ONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      streak_q <= '0;
      last_q   <= BAND_HEAVY;
      qual_q   <= BAND_HEAVY;
    end else if (valid) begin
      streak_q <= streak_d;
      last_q   <= cls;
      if (streak_d == STREAK_MAX) qual_q <= cls;
    end
  end

  assign qual = qual_q;

endmodule

// File: rtl/hop_period_timer.sv
// Counts the switching period and applies the confirmed band only at a wrap.
module hop_period_timer
  import hop_pkg::*;
#(
  parameter int unsigned PER_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  band_e            qual,
  input  logic [PER_W-1:0] per_heavy,
  input  logic [PER_W-1:0] per_medium,
  input  logic [PER_W-1:0] per_light,
  output logic             period_start,
  output band_e            band,
  output logic             band_change,
  output logic             dcm_req
);

  localparam logic [PER_W-1:0] PER_FLOOR = PER_W'(MIN_PERIOD);
  localparam logic [PER_W-1:0] PER_ONE   = PER_W'(1);

  function automatic logic [PER_W-1:0] floor_period(input logic [PER_W-1:0] p);
    return (p < PER_FLOOR) ? PER_FLOOR : p;
  endfunction

  logic [PER_W-1:0] cnt_q;
  logic [PER_W-1:0] len_q;
  logic [PER_W-1:0] next_len;
  logic             wrap;
  logic             start_q;
  logic             chg_q;
  logic             dcm_q;
  band_e            band_q;

  always_comb begin
    unique case (qual)
      BAND_LIGHT:  next_len = floor_period(per_light);
      BAND_MEDIUM: next_len = floor_period(per_medium);
      default:     next_len = floor_period(per_heavy);
    endcase
  end

  assign wrap = (cnt_q == len_q - PER_ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      len_q   <= floor_period(per_heavy);
      start_q <= 1'b0;
      chg_q   <= 1'b0;
      dcm_q   <= 1'b0;
      band_q  <= BAND_HEAVY;
    end else if (wrap) begin
      cnt_q   <= '0;
      len_q   <= next_len;
      start_q <= 1'b1;
      chg_q   <= (qual != band_q);
      dcm_q   <= (qual == BAND_LIGHT);
      band_q  <= qual;
    end else begin
      cnt_q   <= cnt_q + PER_ONE;
      start_q <= 1'b0;
      chg_q   <= 1'b0;
    end
  end

  assign period_start = start_q;
  assign band         = band_q;
  assign band_change  = chg_q;
  assign dcm_req      = dcm_q;

endmodule

// File: rtl/load_hop_selector.sv
module load_hop_selector
  import hop_pkg::*;
#(
  parameter int unsigned LOAD_W = 10,
  parameter int unsigned PER_W  = 16,
  parameter int unsigned QUAL_M = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_valid,
  input  logic [LOAD_W-1:0] load_sample,
  input  logic [LOAD_W-1:0] thr_upper,
  input  logic [LOAD_W-1:0] thr_lower,
  input  logic [PER_W-1:0]  per_heavy,
  input  logic [PER_W-1:0]  per_medium,
  input  logic [PER_W-1:0]  per_light,
  output logic              period_start,
  output logic [1:0]        band_code,
  output logic              dcm_req,
  output logic              band_change
);

  band_e cls;
  band_e qual;
  band_e band;

  hop_band_classifier #(.LOAD_W(LOAD_W)) u_class (
    .sample (load_sample),
    .thr_hi (thr_upper),
    .thr_lo (thr_lower),
    .cls    (cls)
  );

  hop_band_qualifier #(.QUAL_M(QUAL_M)) u_qual (
    .clk   (clk),
    .rst   (rst),
    .valid (load_valid),
    .cls   (cls),
    .qual  (qual)
  );

  hop_period_timer #(.PER_W(PER_W)) u_timer (
    .clk          (clk),
    .rst          (rst),
    .qual         (qual),
    .per_heavy    (per_heavy),
    .per_medium   (per_medium),
    .per_light    (per_light),
    .period_start (period_start),
    .band         (band),
    .band_change  (band_change),
    .dcm_req      (dcm_req)
  );

  assign band_code = band;

endmodule

// File: rtl/hop_selector_checker.sv
module hop_selector_checker (
  input logic       clk,
  input logic       rst,
  input logic       period_start,
  input logic [1:0] band_code,
  input logic       dcm_req,
  input logic       band_change
);

  p_pulse_single_r4: assert property (@(posedge clk) disable iff (rst)
    period_start |=> !period_start);

  p_code_legal_r2: assert property (@(posedge clk) disable iff (rst)
    band_code != 2'b11);

  p_band_at_boundary_r5: assert property (@(posedge clk) disable iff (rst)
    !period_start |-> $stable(band_code));

  p_dcm_follows_band_r6: assert property (@(posedge clk) disable iff (rst)
    dcm_req == (band_code == 2'b00));

  p_change_on_boundary_r7: assert property (@(posedge clk) disable iff (rst)
    band_change |-> period_start);

  p_change_means_new_r7: assert property (@(posedge clk) disable iff (rst)
    band_change |-> (band_code != $past(band_code)));

endmodule

bind load_hop_selector hop_selector_checker u_chk (
  .clk          (clk),
  .rst          (rst),
  .period_start (period_start),
  .band_code    (band_code),
  .dcm_req      (dcm_req),
  .band_change  (band_change)
);

// File: tb/load_hop_selector_test.sv
`timescale 1ns/1ps
module load_hop_selector_test;

  localparam int LW = 10;
  localparam int PW = 16;
  localparam int QM = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          load_valid = 1'b0;
  logic [LW-1:0] load_sample = '0;
  logic [LW-1:0] thr_upper = 10'd256;
  logic [LW-1:0] thr_lower = 10'd102;
  logic [PW-1:0] per_heavy = 16'd8;
  logic [PW-1:0] per_medium = 16'd12;
  logic [PW-1:0] per_light = 16'd20;
  logic          period_start;
  logic [1:0]    band_code;
  logic          dcm_req;
  logic          band_change;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  load_hop_selector #(.LOAD_W(LW), .PER_W(PW), .QUAL_M(QM)) uut (
    .clk(clk), .rst(rst), .load_valid(load_valid), .load_sample(load_sample),
    .thr_upper(thr_upper), .thr_lower(thr_lower), .per_heavy(per_heavy),
    .per_medium(per_medium), .per_light(per_light), .period_start(period_start),
    .band_code(band_code), .dcm_req(dcm_req), .band_change(band_change)
  );

  // Expected-value functions from the requirements
  function automatic logic [1:0] band_of(input logic [LW-1:0] s, input logic [LW-1:0] hi,
                                         input logic [LW-1:0] lo);
    if (s > hi) return 2'b10;
    if (s < lo) return 2'b00;
    return 2'b01;
  endfunction

  function automatic int floor2(input logic [PW-1:0] p);
    return (p < 2) ? 2 : int'(p);
  endfunction

  function automatic int len_of(input logic [1:0] b);
    if (b == 2'b00) return floor2(per_light);
    if (b == 2'b01) return floor2(per_medium);
    return floor2(per_heavy);
  endfunction

  // Cycle model of the requirements
  logic [1:0] m_last, m_qual, m_band;
  int         m_streak, m_cnt, m_len;
  logic       m_start, m_chg;

  always @(posedge clk) begin
    if (rst) begin
      m_last <= 2'b10; m_qual <= 2'b10; m_streak <= 0;
      m_cnt <= 0; m_len <= floor2(per_heavy);
      m_start <= 0; m_chg <= 0; m_band <= 2'b10;
    end else begin
      if (load_valid) begin
        logic [1:0] c;
        int s;
        c = band_of(load_sample, thr_upper, thr_lower);
        s = (c == m_last && m_streak != 0) ? ((m_streak < QM) ? m_streak + 1 : QM) : 1;
        m_last <= c; m_streak <= s;
        if (s == QM) m_qual <= c;
      end
      if (m_cnt == m_len - 1) begin
        m_cnt <= 0; m_len <= len_of(m_qual); m_start <= 1;
        m_chg <= (m_qual != m_band); m_band <= m_qual;
      end else begin
        m_cnt <= m_cnt + 1; m_start <= 0; m_chg <= 0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Every-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      check(period_start == m_start, "R4", "period_start", period_start, m_start);
      check(band_code == m_band, "R5", "band_code", band_code, m_band);
      check(dcm_req == (m_band == 2'b00), "R6", "dcm_req", dcm_req, m_band == 2'b00);
      check(band_change == m_chg, "R7", "band_change", band_change, m_chg);
    end
  end

  task automatic feed(input logic [LW-1:0] s, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      load_valid = 1'b1; load_sample = s;
    end
    @(negedge clk); load_valid = 1'b0;
  endtask

  task automatic wait_pulse();
    do @(negedge clk); while (!period_start);
  endtask

  task automatic gap(output int g);
    g = 0;
    do begin @(negedge clk); g++; end while (!period_start);
  endtask

  int g;
  int chg_seen;

  initial begin
    int unused;
    unused = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    // R1 reset state
    check(band_code == 2'b10, "R1", "reset band_code", band_code, 2);
    check(dcm_req == 0 && period_start == 0 && band_change == 0, "R1", "reset pulses/dcm",
          {dcm_req, period_start, band_change}, 0);
    rst = 1'b0;

    feed(10'd50, 120);
    check(band_code == 2'b00, "R2", "light band", band_code, 0);
    check(dcm_req == 1, "R6", "dcm for light", dcm_req, 1);
    feed(10'd256, 120);
    check(band_code == 2'b01, "R2", "sample equal upper -> medium", band_code, 1);
    feed(10'd102, 120);
    check(band_code == 2'b01, "R2", "sample equal lower -> medium", band_code, 1);
    feed(10'd1000, 120);
    check(band_code == 2'b10, "R2", "heavy band", band_code, 2);

    // R3: QM-1 samples then a break never confirm
    feed(10'd20, QM - 1);
    feed(10'd900, 1);
    repeat (80) @(negedge clk);
    check(band_code == 2'b10, "R3", "short run ignored", band_code, 2);
    // R3: chatter between bands never changes the band
    chg_seen = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      load_valid = 1'b1; load_sample = (i % 2) ? 10'd30 : 10'd600;
      if (band_change) chg_seen++;
    end
    @(negedge clk); load_valid = 1'b0;
    check(chg_seen == 0 && band_code == 2'b10, "R3", "chatter held", chg_seen, 0);
    // R3: invalid gaps do not break a streak
    for (int i = 0; i < QM; i++) begin
      @(negedge clk); load_valid = 1'b1; load_sample = 10'd150;
      @(negedge clk); load_valid = 1'b0; load_sample = 10'd5;
    end
    repeat (60) @(negedge clk);
    check(band_code == 2'b01, "R3", "gapped streak confirms", band_code, 1);

    // R4 period length and floor
    per_medium = 16'd9;
    wait_pulse(); wait_pulse(); gap(g);
    check(g == 9, "R4", "medium gap", g, 9);
    per_medium = 16'd0;
    wait_pulse(); wait_pulse(); gap(g);
    check(g == 2, "R4", "floored gap", g, 2);

    // R8 mid-period write
    per_medium = 16'd30;
    wait_pulse(); wait_pulse();
    repeat (5) @(negedge clk);
    per_medium = 16'd6;
    gap(g);
    check(g == 25, "R8", "remaining after write", g, 25);
    gap(g);
    check(g == 6, "R8", "new length next period", g, 6);

    // Random phase near thresholds with period rewrites
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      load_valid = ($urandom % 2) == 0;
      case ($urandom % 4)
        0: load_sample = 10'd102 + LW'($urandom % 3) - 10'd1;
        1: load_sample = 10'd256 + LW'($urandom % 3) - 10'd1;
        default: load_sample = LW'($urandom);
      endcase
      if (($urandom % 50) == 0) begin
        per_heavy  = PW'($urandom % 12);
        per_medium = PW'($urandom % 20);
        per_light  = PW'($urandom % 30);
      end
    end
    load_valid = 1'b0;
    repeat (10) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule